// File: doc/BRIEF.md
# PWM Channel Waveform Generator

This block turns a stream of clock-enable ticks from an upstream divider into one pulse-width-modulated output. Every incoming tick goes through an 8-bit prescaler that lets one of every k+1 ticks through. Each prescaled step moves a period counter, which runs from zero up to a programmable end value and then returns to zero. A period starts with the active phase, which lasts a programmable number of steps. The inactive phase fills the rest of the period. A control bit picks which logic level counts as active.

When the channel enable is low, the block stops driving its pin: the output-enable drops and the level is parked at zero. Software may rewrite the control word or the period word while the channel runs. The new values take effect at once: the period in progress is abandoned and both counters restart from zero. Turning the channel on restarts them in the same way.

A small state machine tracks the pin state. ST_OFF means not driving. ST_ACT means driving the active level. ST_IDLE means driving the inactive level. Its transitions are:

- EN_TO_ACT (ST_OFF to ST_ACT): the channel turns on with a non-zero active length.
- EN_TO_IDLE (ST_OFF to ST_IDLE): the channel turns on with a zero active length.
- ACT_DONE (ST_ACT to ST_IDLE): the counter reaches the active length.
- WRAP (ST_IDLE to ST_ACT): the counter wraps, or a restart occurs.
- DISABLE (ST_ACT or ST_IDLE to ST_OFF): the channel enable drops.

All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.

Top module: `pwm_chan_gen`

## Requirements
- R1: The prescaler value k is `ctrl_i[7:0]`. The period counter advances once for every k+1 cycles in which `tick_i` is high. Cycles with `tick_i` low have no effect on the counters.
- R2: `ctrl_i[8]` selects the active level. When it is 1, the active phase drives `pwm_o` high and the inactive phase drives it low. When it is 0, both levels are swapped.
- R3: `period_i[31:16]` holds the period length minus one. The counter steps through 0..`period_i[31:16]` and then wraps to 0, so one period lasts that value plus one prescaled steps.
- R4: `period_i[15:0]` is the active length. The output is at the active level while the counter is below the active length, so each period begins with the active phase.
- R5: An active length greater than `period_i[31:16]` behaves exactly as if it were equal to `period_i[31:16]`.
- R6: While `chan_en_i` is low, `pwm_oe_o` is 0 and `pwm_o` is 0 from the following cycle on. Out of reset, both outputs are 0.
- R7: Any change to `ctrl_i` or `period_i` while the channel is enabled restarts both counters from zero at the next clock edge. The new settings are visible on the output in that same cycle.
- R8: An active length of 0 holds the output at the inactive level for the whole period.
- R9: When `chan_en_i` rises, the channel starts with both counters at zero, so the first period begins in the active phase. While the channel is enabled, `pwm_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Divided clock-enable tick from the upstream divider |
| chan_en_i | input | 1 | Channel enable |
| ctrl_i | input | 9 | Control word: [7:0] prescaler k, [8] active level |
| period_i | input | 32 | Period word: [31:16] length minus one, [15:0] active length |
| pwm_o | output | 1 | PWM level |
| pwm_oe_o | output | 1 | Pin drive enable; 0 models a high-impedance pin |

## Verification
The hardest situation to reach from the ports is a register rewrite that lands in the middle of a prescaler run and in the middle of a period. Only a rewrite at that point can tell an immediate restart apart from one that waits for the period to end. The stimulus runs a first setting for an odd number of cycles, chosen so that the switch falls inside both the prescale window and the active phase. It then applies a second setting with a different prescaler and period. Irregular tick patterns from a shift register also make the prescaler hold its count across idle cycles, which exercises the rule that cycles without a tick are ignored.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    // Pin state of one channel.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ACT  = 2'd1,
        ST_IDLE = 2'd2
    } pwm_st_e;

    // Limit the active length to the period end value.
    function automatic logic [15:0] clamp_act(input logic [15:0] act,
                                              input logic [15:0] last);
        return (act > last) ? last : act;
    endfunction

endpackage

// File: rtl/pwm_presc.sv
module pwm_presc #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] k_i,
    output logic             step_o,
    output logic [PRE_W-1:0] cnt_o
);
    logic [PRE_W-1:0] cnt_q;
    logic             wrap;

    assign wrap   = (cnt_q == k_i);
    assign step_o = run_i && !clr_i && tick_i && wrap;
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] pos_o,
    output logic [CNT_W-1:0] pos_nxt_o
);
    logic [CNT_W-1:0] pos_q;

    always_comb begin
        if (!run_i || clr_i) begin
            pos_nxt_o = '0;
        end else if (step_i) begin
            pos_nxt_o = (pos_q == last_i) ? '0 : pos_q + 1'b1;
        end else begin
            pos_nxt_o = pos_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_nxt_o;
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/pwm_out_fsm.sv
module pwm_out_fsm
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] pos_nxt_i,
    input  logic [CNT_W-1:0] act_i,
    input  logic             pol_i,
    output logic             pwm_o,
    output logic             oe_o
);
    pwm_st_e st_q, st_d;
    logic    pol_q;
    logic    in_act;

    assign in_act = (pos_nxt_i < act_i);

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (run_i) st_d = in_act ? ST_ACT : ST_IDLE;
            ST_ACT:  if (!run_i) st_d = ST_OFF;
                     else if (!in_act) st_d = ST_IDLE;
            ST_IDLE: if (!run_i) st_d = ST_OFF;
                     else if (in_act) st_d = ST_ACT;
            default: st_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            pol_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            pol_q <= pol_i;
        end
    end

    // Output decoding.
    always_comb begin
        unique case (st_q)
            ST_ACT:  begin pwm_o = pol_q;  oe_o = 1'b1; end
            ST_IDLE: begin pwm_o = !pol_q; oe_o = 1'b1; end
            default: begin pwm_o = 1'b0;   oe_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen
    import pwm_chan_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16,
    localparam int CTRL_W = PRE_W + 1,
    localparam int PER_W  = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              chan_en_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [PER_W-1:0]  period_i,
    output logic              pwm_o,
    output logic              pwm_oe_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [PER_W-1:0]  per_q;
    logic              en_q;
    logic              restart;
    logic              step;
    logic [PRE_W-1:0]  pc_q;
    logic [CNT_W-1:0]  pos_q, pos_nxt;
    logic [CNT_W-1:0]  last_w, act_w, act_eff;

    assign last_w  = period_i[PER_W-1:CNT_W];
    assign act_w   = period_i[CNT_W-1:0];
    assign act_eff = clamp_act(act_w, last_w);

    // Turn-on or rewrite of either word restarts the channel.
    assign restart = chan_en_i &&
                     (!en_q || (ctrl_i != ctrl_q) || (period_i != per_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            per_q  <= '0;
            en_q   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_i;
            per_q  <= period_i;
            en_q   <= chan_en_i;
        end
    end

    pwm_presc #(.PRE_W(PRE_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (chan_en_i),
        .clr_i  (restart),
        .tick_i (tick_i),
        .k_i    (ctrl_i[PRE_W-1:0]),
        .step_o (step),
        .cnt_o  (pc_q)
    );

    pwm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (chan_en_i),
        .clr_i     (restart),
        .step_i    (step),
        .last_i    (last_w),
        .pos_o     (pos_q),
        .pos_nxt_o (pos_nxt)
    );

    pwm_out_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (chan_en_i),
        .pos_nxt_i (pos_nxt),
        .act_i     (act_eff),
        .pol_i     (ctrl_i[PRE_W]),
        .pwm_o     (pwm_o),
        .oe_o      (pwm_oe_o)
    );
endmodule

// File: rtl/pwm_chan_gen_chk.sv
module pwm_chan_gen_chk #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chan_en_i,
    input logic [PRE_W:0]       ctrl_i,
    input logic [2*CNT_W-1:0]   period_i,
    input logic                 pwm_o,
    input logic                 pwm_oe_o,
    input logic [PRE_W:0]       ctrl_q,
    input logic [2*CNT_W-1:0]   per_q,
    input logic [PRE_W-1:0]     pc_q,
    input logic [CNT_W-1:0]     pos_q
);
    // R6: a disabled channel releases the pin.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en_i |=> (!pwm_oe_o && !pwm_o));

    // R9: an enabled channel drives the pin.
    a_r9_drive: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en_i |=> pwm_oe_o);

    // R9: turn-on starts in the active phase.
    a_r9_start_active: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en_i && !pwm_oe_o && period_i[CNT_W-1:0] != '0
                   && period_i[2*CNT_W-1:CNT_W] != '0)
        |=> (pwm_o == $past(ctrl_i[PRE_W])));

    // R8: zero active length gives the inactive level.
    a_r8_zero_act: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en_i && period_i[CNT_W-1:0] == '0)
        |=> (pwm_o == !$past(ctrl_i[PRE_W])));

    // R3: the period counter never passes the end value.
    a_r3_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= per_q[2*CNT_W-1:CNT_W]);

    // R1: the prescaler count never passes k.
    a_r1_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= ctrl_q[PRE_W-1:0]);
endmodule

bind pwm_chan_gen pwm_chan_gen_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en_i (chan_en_i),
    .ctrl_i    (ctrl_i),
    .period_i  (period_i),
    .pwm_o     (pwm_o),
    .pwm_oe_o  (pwm_oe_o),
    .ctrl_q    (ctrl_q),
    .per_q     (per_q),
    .pc_q      (pc_q),
    .pos_q     (pos_q)
);

// File: tb/test_pwm_chan_gen.sv
module test_pwm_chan_gen;
    localparam int CLK_P = 10;

    typedef struct {
        logic lvl;
        logic oe;
        int   req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        chan_en_i = 1'b0;
    logic [8:0]  ctrl_i = '0;
    logic [31:0] period_i = '0;
    logic        pwm_o, pwm_oe_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   hi_cnt  = 0;
    exp_t q[$];

    // Bench-side model state.
    logic        m_en = 1'b0;
    logic [8:0]  m_ctrl = '0;
    logic [31:0] m_per = '0;
    int          m_pc = 0;
    int          m_pos = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_P/2) clk = !clk;

    pwm_chan_gen i_pwm_chan_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .chan_en_i (chan_en_i),
        .ctrl_i    (ctrl_i),
        .period_i  (period_i),
        .pwm_o     (pwm_o),
        .pwm_oe_o  (pwm_oe_o)
    );

    function automatic void check(input bit ok, input string req,
                                  input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual oe/level=%b expected oe/level=%b at %0t",
                     req, act, exp, $time);
        end
    endfunction

    // Monitor: pops one expected item per cycle.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (pwm_oe_o && pwm_o) hi_cnt++;
                check({pwm_oe_o, pwm_o} == {e.oe, e.lvl},
                      $sformatf("R%0d", e.req), {pwm_oe_o, pwm_o}, {e.oe, e.lvl});
            end
        end
    end

    // Driver: one cycle of stimulus plus the expected result from the requirements.
    task automatic drive(input logic en, input logic [8:0] c, input logic [31:0] p,
                         input bit rnd_tick, input int req);
        exp_t e;
        int k, last, act;
        logic t;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        t = rnd_tick ? lfsr[0] : 1'b1;
        chan_en_i = en; ctrl_i = c; period_i = p; tick_i = t;
        k    = int'(c[7:0]);
        last = int'(p[31:16]);
        act  = int'(p[15:0]);
        if (act > last) act = last;                      // R5
        if (!en) begin
            m_pc = 0; m_pos = 0;                         // R6
        end else if (!m_en || c != m_ctrl || p != m_per) begin
            m_pc = 0; m_pos = 0;                         // R7, R9
        end else if (t) begin                            // R1
            if (m_pc == k) begin
                m_pc = 0;
                m_pos = (m_pos == last) ? 0 : m_pos + 1; // R3
            end else begin
                m_pc++;
            end
        end
        m_en = en; m_ctrl = c; m_per = p;
        e.oe  = en;
        e.lvl = !en ? 1'b0 : ((m_pos < act) ? c[8] : !c[8]); // R2, R4
        e.req = req;
        q.push_back(e);
    endtask

    task automatic run(input int n, input logic en, input logic [8:0] c,
                       input logic [31:0] p, input bit rnd, input int req);
        for (int i = 0; i < n; i++) drive(en, c, p, rnd, req);
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        #3;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state.
        check({pwm_oe_o, pwm_o} == 2'b00, "R6", {pwm_oe_o, pwm_o}, 2'b00);
        rst_n = 1'b1;
        // R3, R4: k=0, period 5, active 2, tick on every cycle.
        run(30, 1'b1, {1'b1, 8'd0}, {16'd4, 16'd2}, 1'b0, 3);
        // R1: k=2 with irregular ticks.
        run(60, 1'b1, {1'b1, 8'd2}, {16'd5, 16'd3}, 1'b1, 1);
        // R2: inverted active level.
        run(30, 1'b1, {1'b0, 8'd1}, {16'd3, 16'd1}, 1'b0, 2);
        // R5: active length larger than the period end value.
        run(24, 1'b1, {1'b1, 8'd0}, {16'd3, 16'd9}, 1'b0, 5);
        // R8: zero active length, both polarities.
        run(20, 1'b1, {1'b1, 8'd0}, {16'd3, 16'd0}, 1'b0, 8);
        run(20, 1'b1, {1'b0, 8'd0}, {16'd3, 16'd0}, 1'b0, 8);
        // R7: rewrite mid-window and mid-active-phase.
        run(7, 1'b1, {1'b1, 8'd3}, {16'd6, 16'd4}, 1'b0, 7);
        run(40, 1'b1, {1'b1, 8'd1}, {16'd2, 16'd1}, 1'b0, 7);
        // R6: disabled channel releases the pin.
        run(10, 1'b0, {1'b1, 8'd1}, {16'd2, 16'd1}, 1'b0, 6);
        // R9: re-enable restarts in the active phase.
        run(25, 1'b1, {1'b1, 8'd1}, {16'd2, 16'd1}, 1'b1, 9);
        drain();
        // R4: counted high cycles for k=1, period 4, active 1 (2 per 8 cycles).
        run(1, 1'b0, {1'b1, 8'd1}, {16'd3, 16'd1}, 1'b0, 6);
        drain();
        hi_cnt = 0;
        run(16, 1'b1, {1'b1, 8'd1}, {16'd3, 16'd1}, 1'b0, 4);
        drain();
        check(hi_cnt == 4, "R4", 2'(hi_cnt), 2'd0);
        if (hi_cnt != 4) $display("  R4 count actual=%0d expected=4", hi_cnt);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule